// File: doc/BRIEF.md
# Active Video Region Detector

This block locates the picture area inside a digitized RGB graphics frame. On every pixel clock it takes one 8-bit sample for each of the three colour channels, together with horizontal and vertical sync. It forms a brightness value for the pixel and compares it with programmable thresholds. From the pixels that pass, it reports the first and last active pixel positions (horizontal span) and the first and last active line positions (vertical span) of the frame.

It has two detection modes. In one-line mode, a single selected row is searched for the horizontal span and a single selected column is searched for the vertical span. Both are chosen in steps of 8, and the usual start values are row select 6 (line 48) and column select 55 (pixel 440). In whole-frame mode, every pixel of the frame contributes to both spans. Configuration arrives on plain ports. The four results are held stable for a whole frame, so firmware or a neighbouring block can read them at any time.

Top module: `vidact_finder`

## Requirements
- R1: The brightness of a pixel is the largest of its three channel values. A pixel is active for a search when its brightness is greater than or equal to that search's threshold. A pixel below the threshold is blanking.
- R2: The pixel position is 0 in the cycle where `hsync` rises and increases by one each cycle after that. The line position is 0 in the cycle where `vsync` rises and increases by one at each `hsync` rising edge. Both positions are 11 bits wide and saturate at 2047.
- R3: In one-line mode (`mode_frame`=0), only pixels on line `row_sel`*8 feed `h_start`/`h_end`. For example, `row_sel`=6 selects line 48.
- R4: In one-line mode, only pixels at position `col_sel`*8 feed `v_start`/`v_end`. For example, `col_sel`=55 selects pixel 440.
- R5: In whole-frame mode (`mode_frame`=1), every active pixel of the frame feeds both spans. `h_start`/`h_end` report the smallest and largest active pixel position, and `v_start`/`v_end` report the smallest and largest active line position.
- R6: When `v_thresh_en`=0, `h_thresh` is the threshold for both searches. When `v_thresh_en`=1, the vertical search uses `v_thresh` and the horizontal search still uses `h_thresh`.
- R7: The results change only in the cycle after a `vsync` rising edge. They then show the spans of the frame that this edge ended. The first `vsync` edge after reset does not update them.
- R8: A span that found no active pixel reads start=2047 and end=0. This is also the value of all four results after reset.
- R9: A change of `mode_frame` discards the frame in progress. The next `vsync` edge leaves the results unchanged. The frame that follows that edge is reported normally.
- R10: Whenever a span holds a found region, its start is less than or equal to its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_r | input | 8 | Red channel sample |
| pix_g | input | 8 | Green channel sample |
| pix_b | input | 8 | Blue channel sample |
| hsync | input | 1 | Horizontal sync; rising edge starts a line |
| vsync | input | 1 | Vertical sync; rising edge starts a frame |
| mode_frame | input | 1 | 1: whole-frame scan, 0: one-line scan |
| row_sel | input | 8 | Row for the horizontal search, in units of 8 lines |
| col_sel | input | 8 | Column for the vertical search, in units of 8 pixels |
| h_thresh | input | 8 | Horizontal threshold (also vertical when not split) |
| v_thresh | input | 8 | Vertical threshold used when split |
| v_thresh_en | input | 1 | 1: vertical search uses `v_thresh` |
| h_start | output | 11 | First active pixel position |
| h_end | output | 11 | Last active pixel position |
| v_start | output | 11 | First active line position |
| v_end | output | 11 | Last active line position |

## Verification
The properties assume that `mode_frame` is held steady while reset is asserted. They also assume that every `vsync` rising edge arrives in the same cycle as an `hsync` rising edge. The stimulus builds every frame so that the sync pulses begin on pixel 0 and the frame edge falls on line 0. It changes thresholds and selections only in the cycle just before a frame begins. It changes the mode either at a frame boundary or once in the middle of a frame, and both cases exercise the discard rule.

// File: rtl/vidact_pkg.sv
package vidact_pkg;
    localparam int unsigned DEF_PIX_W     = 8;
    localparam int unsigned DEF_CH_N      = 3;
    localparam int unsigned DEF_COORD_W   = 11;
    localparam int unsigned DEF_SEL_W     = 8;
    localparam int unsigned DEF_SEL_SHIFT = 3;

    // Search axes handled by one span tracker each
    localparam int unsigned AX_H = 0;
    localparam int unsigned AX_V = 1;
    localparam int unsigned AX_N = 2;
endpackage

// File: rtl/vidact_luma.sv
module vidact_luma #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned CH_N  = 3
) (
    input  logic [CH_N*PIX_W-1:0] chans,
    output logic [PIX_W-1:0]      luma
);
    // Brightness: the largest channel value of the pixel
    always_comb begin
        luma = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (chans[i*PIX_W +: PIX_W] > luma) begin
                luma = chans[i*PIX_W +: PIX_W];
            end
        end
    end
endmodule

// File: rtl/vidact_timebase.sv
module vidact_timebase #(
    parameter int unsigned COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync,
    input  logic               vsync,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic               frame_start
);
    typedef struct packed {
        logic               hs_prev;
        logic               vs_prev;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } tb_state_t;

    localparam logic [COORD_W-1:0] COORD_TOP = {COORD_W{1'b1}};

    tb_state_t st_q, st_d;
    logic      hs_rise;
    logic      vs_rise;

    always_comb begin
        hs_rise = hsync & ~st_q.hs_prev;
        vs_rise = vsync & ~st_q.vs_prev;
        st_d         = st_q;
        st_d.hs_prev = hsync;
        st_d.vs_prev = vsync;
        if (hs_rise) begin
            st_d.x = '0;
        end else if (st_q.x != COORD_TOP) begin
            st_d.x = st_q.x + 1'b1;
        end
        if (vs_rise) begin
            st_d.y = '0;
        end else if (hs_rise && (st_q.y != COORD_TOP)) begin
            st_d.y = st_q.y + 1'b1;
        end
    end

    // Position of the pixel presented in this cycle
    assign cur_x       = st_d.x;
    assign cur_y       = st_d.y;
    assign frame_start = vs_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vidact_span.sv
module vidact_span #(
    parameter int unsigned COORD_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               discard,
    input  logic               frame_start,
    input  logic               commit,
    input  logic               hit,
    input  logic [COORD_W-1:0] coord,
    output logic [COORD_W-1:0] res_lo,
    output logic [COORD_W-1:0] res_hi
);
    localparam logic [COORD_W-1:0] NONE_LO = {COORD_W{1'b1}};
    localparam logic [COORD_W-1:0] NONE_HI = '0;

    typedef struct packed {
        logic [COORD_W-1:0] acc_lo;
        logic [COORD_W-1:0] acc_hi;
        logic [COORD_W-1:0] res_lo;
        logic [COORD_W-1:0] res_hi;
    } sp_state_t;

    sp_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (discard) begin
            st_d.acc_lo = NONE_LO;
            st_d.acc_hi = NONE_HI;
        end else begin
            if (frame_start) begin
                if (commit) begin
                    st_d.res_lo = st_q.acc_lo;
                    st_d.res_hi = st_q.acc_hi;
                end
                st_d.acc_lo = NONE_LO;
                st_d.acc_hi = NONE_HI;
            end
            if (hit) begin
                if (coord < st_d.acc_lo) st_d.acc_lo = coord;
                if (coord > st_d.acc_hi) st_d.acc_hi = coord;
            end
        end
    end

    assign res_lo = st_q.res_lo;
    assign res_hi = st_q.res_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{acc_lo: NONE_LO, acc_hi: NONE_HI,
                      res_lo: NONE_LO, res_hi: NONE_HI};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/vidact_finder.sv
module vidact_finder
    import vidact_pkg::*;
#(
    parameter int unsigned PIX_W     = DEF_PIX_W,
    parameter int unsigned COORD_W   = DEF_COORD_W,
    parameter int unsigned SEL_W     = DEF_SEL_W,
    parameter int unsigned SEL_SHIFT = DEF_SEL_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIX_W-1:0]   pix_r,
    input  logic [PIX_W-1:0]   pix_g,
    input  logic [PIX_W-1:0]   pix_b,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               mode_frame,
    input  logic [SEL_W-1:0]   row_sel,
    input  logic [SEL_W-1:0]   col_sel,
    input  logic [PIX_W-1:0]   h_thresh,
    input  logic [PIX_W-1:0]   v_thresh,
    input  logic               v_thresh_en,
    output logic [COORD_W-1:0] h_start,
    output logic [COORD_W-1:0] h_end,
    output logic [COORD_W-1:0] v_start,
    output logic [COORD_W-1:0] v_end
);
    localparam int unsigned CH_N = DEF_CH_N;

    typedef struct packed {
        logic mode;
        logic armed;
    } ctl_state_t;

    ctl_state_t         ctl_q, ctl_d;
    logic [PIX_W-1:0]   luma;
    logic [COORD_W-1:0] cur_x, cur_y;
    logic               frame_start;
    logic               mode_chg;
    logic               commit;
    logic [PIX_W-1:0]   v_th;
    logic               h_act, v_act;
    logic [COORD_W-1:0] row_coord, col_coord;
    logic [AX_N-1:0]    hit_ax;
    logic [COORD_W-1:0] coord_ax [AX_N];
    logic [COORD_W-1:0] lo_ax    [AX_N];
    logic [COORD_W-1:0] hi_ax    [AX_N];

    vidact_luma #(.PIX_W(PIX_W), .CH_N(CH_N)) u_luma (
        .chans ({pix_b, pix_g, pix_r}),
        .luma  (luma)
    );

    vidact_timebase #(.COORD_W(COORD_W)) u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync       (hsync),
        .vsync       (vsync),
        .cur_x       (cur_x),
        .cur_y       (cur_y),
        .frame_start (frame_start)
    );

    always_comb begin
        mode_chg = (mode_frame != ctl_q.mode);
        commit   = frame_start & ctl_q.armed & ~mode_chg;
        ctl_d      = ctl_q;
        ctl_d.mode = mode_frame;
        if (mode_chg) begin
            ctl_d.armed = 1'b0;
        end else if (frame_start) begin
            ctl_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Threshold tests and search-line selection
    assign v_th      = v_thresh_en ? v_thresh : h_thresh;
    assign h_act     = (luma >= h_thresh);
    assign v_act     = (luma >= v_th);
    assign row_coord = COORD_W'(row_sel) << SEL_SHIFT;
    assign col_coord = COORD_W'(col_sel) << SEL_SHIFT;

    assign hit_ax[AX_H]   = h_act & (mode_frame | (cur_y == row_coord));
    assign coord_ax[AX_H] = cur_x;
    assign hit_ax[AX_V]   = v_act & (mode_frame | (cur_x == col_coord));
    assign coord_ax[AX_V] = cur_y;

    for (genvar a = 0; a < AX_N; a++) begin : g_axis
        vidact_span #(.COORD_W(COORD_W)) u_span (
            .clk         (clk),
            .rst_n       (rst_n),
            .discard     (mode_chg),
            .frame_start (frame_start),
            .commit      (commit),
            .hit         (hit_ax[a]),
            .coord       (coord_ax[a]),
            .res_lo      (lo_ax[a]),
            .res_hi      (hi_ax[a])
        );
    end

    assign h_start = lo_ax[AX_H];
    assign h_end   = hi_ax[AX_H];
    assign v_start = lo_ax[AX_V];
    assign v_end   = hi_ax[AX_V];
endmodule

// File: rtl/vidact_checker.sv
module vidact_checker #(
    parameter int unsigned COORD_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               vsync,
    input logic               mode_frame,
    input logic [COORD_W-1:0] h_start,
    input logic [COORD_W-1:0] h_end,
    input logic [COORD_W-1:0] v_start,
    input logic [COORD_W-1:0] v_end
);
    localparam logic [COORD_W-1:0] NONE_LO = {COORD_W{1'b1}};

    logic               vs_prev;
    logic               vs_edge;
    logic [4*COORD_W-1:0] res_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_prev <= 1'b0;
        else        vs_prev <= vsync;
    end

    assign vs_edge = vsync & ~vs_prev;
    assign res_all = {h_start, h_end, v_start, v_end};

    p_span_order_h_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (h_start <= h_end) || ((h_start == NONE_LO) && (h_end == '0)));

    p_span_order_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (v_start <= v_end) || ((v_start == NONE_LO) && (v_end == '0)));

    p_update_on_vsync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_all) |-> $past(vs_edge));

    p_mode_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_frame != $past(mode_frame)) |=> $stable(res_all));
endmodule

bind vidact_finder vidact_checker #(.COORD_W(COORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vsync      (vsync),
    .mode_frame (mode_frame),
    .h_start    (h_start),
    .h_end      (h_end),
    .v_start    (v_start),
    .v_end      (v_end)
);

// File: tb/vidact_finder_bench.sv
module vidact_finder_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  pix_r, pix_g, pix_b;
    logic        hsync, vsync, mode_frame;
    logic [7:0]  row_sel, col_sel, h_thresh, v_thresh;
    logic        v_thresh_en;
    logic [10:0] h_start, h_end, v_start, v_end;

    always #2 clk = ~clk;

    vidact_finder u_vidact_finder (
        .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .hsync(hsync), .vsync(vsync), .mode_frame(mode_frame),
        .row_sel(row_sel), .col_sel(col_sel), .h_thresh(h_thresh),
        .v_thresh(v_thresh), .v_thresh_en(v_thresh_en),
        .h_start(h_start), .h_end(h_end), .v_start(v_start), .v_end(v_end)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench model state: accumulating (a_) and committed (c_) spans
    int a_hlo, a_hhi, a_vlo, a_vhi;
    int c_hlo = 2047, c_hhi = 0, c_vlo = 2047, c_vhi = 0;
    bit armed_m = 0;
    bit mode_m = 0;
    string last_tag = "R7 R8 after reset";
    int xa, xb, ya, yb;

    task automatic chk(input string tag, input string nm, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, nm, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "h_start", int'(h_start), c_hlo);
        chk(tag, "h_end",   int'(h_end),   c_hhi);
        chk(tag, "v_start", int'(v_start), c_vlo);
        chk(tag, "v_end",   int'(v_end),   c_vhi);
    endtask

    function automatic int lum(input int r, input int g, input int b);
        int m;
        m = r;
        if (g > m) m = g;
        if (b > m) m = b;
        return m; // R1: brightness is the largest channel
    endfunction

    task automatic clear_acc();
        a_hlo = 2047; a_hhi = 0; a_vlo = 2047; a_vhi = 0;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    // kind 0: sparse random, 1: threshold-exact rectangle, 2: dark, 3: last pixel bright
    task automatic run_frame(input int np, input int nl, input int kind,
                             input int flip_line, input string tag);
        for (int l = 0; l < nl; l++) begin
            for (int p = 0; p < np; p++) begin
                int r, g, b, lo_th, hi_th, vth, x, y, lm;
                bit chg;
                @(negedge clk);
                if (l == 0 && p == 1) check_all(last_tag);
                vth   = v_thresh_en ? int'(v_thresh) : int'(h_thresh);
                lo_th = (vth < int'(h_thresh)) ? vth : int'(h_thresh);
                hi_th = (vth > int'(h_thresh)) ? vth : int'(h_thresh);
                r = 0; g = 0; b = 0;
                case (kind)
                    0: begin
                        if ($urandom % 40 == 0) begin
                            r = $urandom % 256; g = $urandom % 256; b = $urandom % 256;
                        end else begin
                            r = $urandom % lo_th; g = $urandom % lo_th; b = $urandom % lo_th;
                        end
                    end
                    1: begin
                        if (p >= xa && p <= xb && l >= ya && l <= yb) begin
                            g = hi_th; r = lo_th - 1; b = lo_th - 1;
                        end else begin
                            b = lo_th - 1;
                        end
                    end
                    2: begin
                        r = lo_th - 1; g = lo_th - 1; b = lo_th - 1;
                    end
                    default: begin
                        if (l == 1 && p == np - 1) r = 255;
                    end
                endcase
                pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
                hsync = (p < 2);
                vsync = (l == 0 && p < 3);
                if (l == flip_line && p == 5) mode_frame = ~mode_frame;
                // Model of the requirements
                chg = (mode_frame != mode_m);
                mode_m = mode_frame;
                if (chg) begin
                    clear_acc(); // R9: partial frame dropped
                    armed_m = 0;
                end else begin
                    if (l == 0 && p == 0) begin
                        if (armed_m) begin
                            c_hlo = a_hlo; c_hhi = a_hhi; c_vlo = a_vlo; c_vhi = a_vhi;
                        end
                        clear_acc();
                        armed_m = 1;
                    end
                    x = (p > 2047) ? 2047 : p; // R2: saturating positions
                    y = (l > 2047) ? 2047 : l;
                    lm = lum(r, g, b);
                    if (lm >= int'(h_thresh) && (mode_frame || y == int'(row_sel) * 8)) begin
                        if (x < a_hlo) a_hlo = x;
                        if (x > a_hhi) a_hhi = x;
                    end
                    if (lm >= vth && (mode_frame || x == int'(col_sel) * 8)) begin
                        if (y < a_vlo) a_vlo = y;
                        if (y > a_vhi) a_vhi = y;
                    end
                end
            end
        end
        last_tag = tag;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; pix_r = 0; pix_g = 0; pix_b = 0; hsync = 0; vsync = 0;
        mode_frame = 0; row_sel = 8'd6; col_sel = 8'd55;
        h_thresh = 8'd32; v_thresh = 8'd32; v_thresh_en = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_all("R8 reset state");
        rst_n = 1;

        // Start-up selections: line 48 for horizontal, pixel 440 (outside frame) for vertical
        xa = 5; xb = 40; ya = 10; yb = 55;
        run_frame(48, 64, 1, -1, "R3 R4 R8 start-up selects");
        run_frame(48, 64, 1, -1, "R3 R4 R7 R8 start-up selects");

        settle();
        row_sel = 8'd2; col_sel = 8'd3; xa = 7; xb = 33; ya = 4; yb = 50;
        run_frame(48, 64, 1, -1, "R1 R3 R4 threshold-exact one-line");

        settle();
        v_thresh_en = 1; v_thresh = 8'd90; h_thresh = 8'd40;
        run_frame(48, 64, 0, -1, "R6 split thresholds");
        run_frame(48, 64, 1, -1, "R1 R6 split threshold-exact");

        settle();
        mode_frame = 1; // mode change at a boundary drops this frame (R9)
        xa = 2; xb = 45; ya = 1; yb = 62;
        run_frame(48, 64, 1, -1, "R9 boundary mode change");
        run_frame(48, 64, 1, -1, "R5 whole-frame rectangle");

        for (int k = 0; k < 10; k++) begin
            settle();
            row_sel = 8'($urandom % 6); col_sel = 8'($urandom % 6);
            h_thresh = 8'(8 + $urandom % 200); v_thresh = 8'(8 + $urandom % 200);
            v_thresh_en = 1'($urandom % 2);
            if (k % 4 == 3) mode_frame = ~mode_frame;
            run_frame(48, 64, 0, -1, "R1 R3 R4 R5 R6 R10 random");
        end

        settle();
        run_frame(48, 64, 2, -1, "R8 dark frame");
        run_frame(48, 64, 0, 20, "R9 mid-frame mode change");
        run_frame(48, 64, 0, -1, "R9 R7 frame after change");

        settle();
        mode_frame = 1;
        run_frame(48, 8, 2, -1, "R9 settle mode");
        run_frame(2100, 3, 3, -1, "R2 position saturation");
        run_frame(48, 4, 2, -1, "R8 dark tail");
        run_frame(48, 4, 2, -1, "R8 final");
        @(negedge clk);
        check_all(last_tag);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule